// File: doc/BRIEF.md
# Spark Pulse Timing Analyzer

This block watches each machining pulse of a spark erosion generator and measures how long the gap holds off before it breaks down. It receives three comparator bits, already synchronized to its sample clock, that tell whether the gap voltage is above a low, a middle and a high threshold. It also receives a strobe that is high for the whole duration of each pulse. One count of the ignition delay is one sample clock tick, so a 20 MHz clock gives a resolution of 0.05 µs.

When a pulse ends, the block latches the delay count and places the pulse in exactly one quality class. It does this by looking at which comparators were seen during the pulse and by comparing the delay with the programmed on-time. The on-time is held in ticks, that is the duration in µs multiplied by 20. A small byte-wide register port lets a host do three things: read a saturating, clear-on-read counter for each class, read the latched delay as two bytes, and write the on-time.

Top module: `spark_pulse_analyzer`

## Requirements
- R1: The delay count of a pulse is the number of clocks, counted from the first clock on which `pulse_on_i` is high, during which `pulse_on_i` and `gap_above_hi_i` are both high, up to the first clock on which `gap_above_hi_i` is low. Any later rise of `gap_above_hi_i` in the same pulse is ignored. The count saturates at 0xFFFF.
- R2: The latched delay changes only at the clock edge that first samples `pulse_on_i` low after it was high. A read of the delay while a pulse is running returns the value of the previous pulse.
- R3: A host write to address 0 sets the low byte of the on-time in ticks, and a write to address 1 sets the high byte. After reset the on-time is 20 ticks.
- R4: Every pulse increments exactly one class counter. The first of these rules that matches decides the class: short circuit if `gap_above_lo_i` was never high during the pulse; open if `gap_above_hi_i` never fell during the pulse, or if the delay is greater than or equal to the on-time; arc if the delay is 0; abnormal if `gap_above_mid_i` was never high from the breakdown clock to the end of the pulse; otherwise normal erosion.
- R5: The read map is: address 0 erosion, 1 arc, 2 open, 3 short, 4 abnormal, 5 delay low byte, 6 delay high byte, 7 always 0. Read data is registered. It appears on `host_rdata_o` after the clock edge that samples `host_rd_i` high, and it holds when no read is made.
- R6: A class counter stays at 0xFF once it has reached 0xFF, until it is read.
- R7: Reading a class counter returns its value and clears it to 0. If that class is incremented on the same clock, the read returns the old value and the counter becomes 1.
- R8: Reading address 5 also saves the high byte of the latched delay. Address 6 returns that saved byte, even if a later pulse has changed the latch since.
- R9: After reset all counters, the latched delay and `host_rdata_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low reset, synchronous release |
| pulse_on_i | input | 1 | High while a generator pulse is applied |
| gap_above_lo_i | input | 1 | Gap voltage above the lowest threshold |
| gap_above_mid_i | input | 1 | Gap voltage above the middle threshold |
| gap_above_hi_i | input | 1 | Gap voltage above the highest threshold |
| host_addr_i | input | 3 | Register address |
| host_rd_i | input | 1 | Read strobe, one clock per read |
| host_wr_i | input | 1 | Write strobe, one clock per write |
| host_wdata_i | input | 8 | Write data |
| host_rdata_o | output | 8 | Registered read data |

## Verification
Most internal faults in this block show up at the host port one clock after the pulse ends. A delay counter that keeps running after breakdown, or that does not restart, gives a wrong value at address 5 or 6 on the first read after that edge. A wrong classification priority moves the count to a different address. A counter that wraps or loses an increment that coincides with a read shows up on the next read of that class. A stale or torn high-byte snapshot only becomes visible when a second pulse ends between the two byte reads, so the tests place one there on purpose.

// File: rtl/spa_pkg.sv
package spa_pkg;

  localparam int DLY_W = 16;
  localparam int NCLS  = 5;
  localparam int AW    = 3;

  // Class codes double as read addresses of the class counters.
  typedef enum logic [AW-1:0] {
    CLS_EROSION  = 3'd0,
    CLS_ARC      = 3'd1,
    CLS_OPEN     = 3'd2,
    CLS_SHORT    = 3'd3,
    CLS_ABNORMAL = 3'd4
  } cls_e;

  localparam logic [AW-1:0] ADDR_DLY_LO = 3'd5;
  localparam logic [AW-1:0] ADDR_DLY_HI = 3'd6;
  localparam logic [AW-1:0] ADDR_ONT_LO = 3'd0;
  localparam logic [AW-1:0] ADDR_ONT_HI = 3'd1;

  // Saturating step of the delay counter.
  function automatic logic [DLY_W-1:0] dly_step(input logic [DLY_W-1:0] v);
    return (v == {DLY_W{1'b1}}) ? v : v + 1'b1;
  endfunction

  // Class decision, earliest rule wins.
  function automatic cls_e classify(input logic [DLY_W-1:0] dly,
                                    input logic [DLY_W-1:0] on_ticks,
                                    input logic             lo_seen,
                                    input logic             broke,
                                    input logic             mid_seen);
    if (!lo_seen)                      return CLS_SHORT;
    else if (!broke || dly >= on_ticks) return CLS_OPEN;
    else if (dly == '0)                return CLS_ARC;
    else if (!mid_seen)                return CLS_ABNORMAL;
    else                               return CLS_EROSION;
  endfunction

endpackage

// File: rtl/spa_gap_meter.sv
module spa_gap_meter
  import spa_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse_on,
  input  logic             above_lo,
  input  logic             above_mid,
  input  logic             above_hi,
  input  logic [DLY_W-1:0] on_ticks,
  output logic             ev_start,
  output logic             ev_end,
  output cls_e             ev_cls,
  output logic [DLY_W-1:0] run_cnt,
  output logic             broke,
  output logic             lo_seen,
  output logic [DLY_W-1:0] dly_hold
);

  logic             pa_q;
  logic             mid_seen;
  logic [DLY_W-1:0] cnt_b, cnt_n;
  logic             brk_b, brk_n, lo_b, lo_n, mid_b, mid_n;

  assign ev_start = pulse_on && !pa_q;
  assign ev_end   = pa_q && !pulse_on;
  assign ev_cls   = classify(run_cnt, on_ticks, lo_seen, broke, mid_seen);

  always_comb begin
    cnt_b = ev_start ? '0   : run_cnt;
    brk_b = ev_start ? 1'b0 : broke;
    lo_b  = ev_start ? 1'b0 : lo_seen;
    mid_b = ev_start ? 1'b0 : mid_seen;
    cnt_n = cnt_b;
    brk_n = brk_b;
    lo_n  = lo_b;
    mid_n = mid_b;
    if (pulse_on) begin
      lo_n = lo_b | above_lo;
      if (!brk_b && above_hi) begin
        cnt_n = dly_step(cnt_b);
      end else begin
        brk_n = 1'b1;
        mid_n = mid_b | above_mid;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pa_q     <= 1'b0;
      run_cnt  <= '0;
      broke    <= 1'b0;
      lo_seen  <= 1'b0;
      mid_seen <= 1'b0;
      dly_hold <= '0;
    end else begin
      pa_q     <= pulse_on;
      run_cnt  <= cnt_n;
      broke    <= brk_n;
      lo_seen  <= lo_n;
      mid_seen <= mid_n;
      if (ev_end) dly_hold <= run_cnt;
    end
  end

endmodule

// File: rtl/spa_class_bank.sv
module spa_class_bank #(
  parameter int NUM   = 5,
  parameter int CNT_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM-1:0]            inc,
  input  logic [NUM-1:0]            clr,
  output logic [NUM-1:0][CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  for (genvar g = 0; g < NUM; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt[g] <= '0;
      end else if (inc[g]) begin
        if (clr[g])             cnt[g] <= ONE;
        else if (cnt[g] != TOP) cnt[g] <= cnt[g] + ONE;
      end else if (clr[g]) begin
        cnt[g] <= '0;
      end
    end
  end

endmodule

// File: rtl/spa_host_port.sv
module spa_host_port
  import spa_pkg::*;
#(
  parameter int               NUM       = 5,
  parameter int               CNT_W     = 8,
  parameter logic [DLY_W-1:0] ONT_RESET = DLY_W'(20)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [AW-1:0]             addr,
  input  logic                      rd,
  input  logic                      wr,
  input  logic [7:0]                wdata,
  input  logic [NUM-1:0][CNT_W-1:0] cnt,
  input  logic [DLY_W-1:0]          dly_hold,
  output logic [7:0]                rdata,
  output logic [DLY_W-1:0]          on_ticks,
  output logic [NUM-1:0]            clr
);

  logic [7:0] hi_snap;
  logic [7:0] sel;

  for (genvar g = 0; g < NUM; g++) begin : g_clr
    assign clr[g] = rd && (addr == AW'(g));
  end

  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM; i++) begin
      if (addr == AW'(i)) sel = 8'(cnt[i]);
    end
    if (addr == ADDR_DLY_LO) sel = dly_hold[7:0];
    if (addr == ADDR_DLY_HI) sel = hi_snap;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata    <= '0;
      hi_snap  <= '0;
      on_ticks <= ONT_RESET;
    end else begin
      if (rd) rdata <= sel;
      if (rd && addr == ADDR_DLY_LO) hi_snap <= dly_hold[15:8];
      if (wr && addr == ADDR_ONT_LO) on_ticks[7:0]  <= wdata;
      if (wr && addr == ADDR_ONT_HI) on_ticks[15:8] <= wdata;
    end
  end

endmodule

// File: rtl/spark_pulse_analyzer.sv
module spark_pulse_analyzer
  import spa_pkg::*;
#(
  parameter int               CNT_W     = 8,
  parameter logic [DLY_W-1:0] ONT_RESET = DLY_W'(20)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pulse_on_i,
  input  logic       gap_above_lo_i,
  input  logic       gap_above_mid_i,
  input  logic       gap_above_hi_i,
  input  logic [2:0] host_addr_i,
  input  logic       host_rd_i,
  input  logic       host_wr_i,
  input  logic [7:0] host_wdata_i,
  output logic [7:0] host_rdata_o
);

  logic                       ev_start, ev_end;
  cls_e                       ev_cls;
  logic [DLY_W-1:0]           run_cnt, dly_hold, on_ticks;
  logic                       broke, lo_seen;
  logic [NCLS-1:0]            inc_vec, clr_vec;
  logic [NCLS-1:0][CNT_W-1:0] cls_cnt;

  spa_gap_meter u_meter (
    .clk      (clk),
    .rst_n    (rst_n),
    .pulse_on (pulse_on_i),
    .above_lo (gap_above_lo_i),
    .above_mid(gap_above_mid_i),
    .above_hi (gap_above_hi_i),
    .on_ticks (on_ticks),
    .ev_start (ev_start),
    .ev_end   (ev_end),
    .ev_cls   (ev_cls),
    .run_cnt  (run_cnt),
    .broke    (broke),
    .lo_seen  (lo_seen),
    .dly_hold (dly_hold)
  );

  always_comb begin
    for (int i = 0; i < NCLS; i++) begin
      inc_vec[i] = ev_end && (ev_cls == cls_e'(i));
    end
  end

  spa_class_bank #(.NUM(NCLS), .CNT_W(CNT_W)) u_bank (
    .clk  (clk),
    .rst_n(rst_n),
    .inc  (inc_vec),
    .clr  (clr_vec),
    .cnt  (cls_cnt)
  );

  spa_host_port #(.NUM(NCLS), .CNT_W(CNT_W), .ONT_RESET(ONT_RESET)) u_host (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (host_addr_i),
    .rd      (host_rd_i),
    .wr      (host_wr_i),
    .wdata   (host_wdata_i),
    .cnt     (cls_cnt),
    .dly_hold(dly_hold),
    .rdata   (host_rdata_o),
    .on_ticks(on_ticks),
    .clr     (clr_vec)
  );

endmodule

// File: rtl/spark_pulse_analyzer_chk.sv
module spark_pulse_analyzer_chk
  import spa_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       pulse_on,
  input logic                       ev_start,
  input logic                       ev_end,
  input cls_e                       ev_cls,
  input logic [DLY_W-1:0]           run_cnt,
  input logic                       broke,
  input logic                       lo_seen,
  input logic [DLY_W-1:0]           dly_hold,
  input logic [NCLS-1:0]            inc_vec,
  input logic [NCLS-1:0]            clr_vec,
  input logic [NCLS-1:0][CNT_W-1:0] cls_cnt
);

  AST_DLY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    broke && pulse_on && !ev_start |=> $stable(run_cnt)); // R1
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_end |=> $stable(dly_hold)); // R2
  AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ev_end |=> dly_hold == $past(run_cnt)); // R2
  AST_ONE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_end |-> $countones(inc_vec) == 1); // R4
  AST_NO_STRAY_INC: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_end |-> $countones(inc_vec) == 0); // R4
  AST_SHORT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ev_end && !lo_seen |-> ev_cls == CLS_SHORT); // R4
  AST_ARC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ev_end && ev_cls == CLS_ARC |-> run_cnt == '0); // R4

  for (genvar g = 0; g < NCLS; g++) begin : g_cnt_chk
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      cls_cnt[g] == {CNT_W{1'b1}} && !clr_vec[g] |=> cls_cnt[g] == {CNT_W{1'b1}}); // R6
    AST_NO_LOST_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      inc_vec[g] && clr_vec[g] |=> cls_cnt[g] == CNT_W'(1)); // R7
    AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      clr_vec[g] && !inc_vec[g] |=> cls_cnt[g] == '0); // R7
  end

endmodule

bind spark_pulse_analyzer spark_pulse_analyzer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .pulse_on(pulse_on_i),
  .ev_start(ev_start),
  .ev_end  (ev_end),
  .ev_cls  (ev_cls),
  .run_cnt (run_cnt),
  .broke   (broke),
  .lo_seen (lo_seen),
  .dly_hold(dly_hold),
  .inc_vec (inc_vec),
  .clr_vec (clr_vec),
  .cls_cnt (cls_cnt)
);

// File: tb/spark_pulse_analyzer_bench.sv
module spark_pulse_analyzer_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pulse_on = 1'b0, a_lo = 1'b0, a_mid = 1'b0, a_hi = 1'b0;
  logic [2:0] h_addr = '0;
  logic       h_rd = 1'b0, h_wr = 1'b0;
  logic [7:0] h_wdata = '0;
  logic [7:0] h_rdata;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] mid_val;

  always #10 clk = ~clk;

  spark_pulse_analyzer u_spark_pulse_analyzer (
    .clk            (clk),
    .rst_n          (rst_n),
    .pulse_on_i     (pulse_on),
    .gap_above_lo_i (a_lo),
    .gap_above_mid_i(a_mid),
    .gap_above_hi_i (a_hi),
    .host_addr_i    (h_addr),
    .host_rd_i      (h_rd),
    .host_wr_i      (h_wr),
    .host_wdata_i   (h_wdata),
    .host_rdata_o   (h_rdata)
  );

  // Class read addresses (R5)
  localparam logic [2:0] A_ERO = 3'd0, A_ARC = 3'd1, A_OPN = 3'd2,
                         A_SHT = 3'd3, A_ABN = 3'd4;

  typedef struct packed {
    logic [15:0] hi_len;
    logic [15:0] tot;
    logic        lo;
    logic        mid;
    logic [2:0]  cls;
    logic [15:0] dly;
  } vec_t;

  // On-time stays at its reset value of 20 ticks for this table.
  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{16'd5,  16'd30, 1'b1, 1'b1, A_ERO, 16'd5},
    '{16'd0,  16'd30, 1'b1, 1'b1, A_ARC, 16'd0},
    '{16'd20, 16'd20, 1'b1, 1'b1, A_OPN, 16'd20},
    '{16'd25, 16'd40, 1'b1, 1'b1, A_OPN, 16'd25},
    '{16'd0,  16'd15, 1'b0, 1'b0, A_SHT, 16'd0},
    '{16'd7,  16'd30, 1'b1, 1'b0, A_ABN, 16'd7},
    '{16'd19, 16'd30, 1'b1, 1'b1, A_ERO, 16'd19},
    '{16'd12, 16'd12, 1'b1, 1'b1, A_OPN, 16'd12}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    h_addr = a;
    h_rd   = 1'b1;
    @(negedge clk);
    h_rd = 1'b0;
    d    = h_rdata;
  endtask

  task automatic do_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    h_addr  = a;
    h_wdata = d;
    h_wr    = 1'b1;
    @(negedge clk);
    h_wr = 1'b0;
  endtask

  task automatic read_dly(output int v);
    logic [7:0] lo, hi;
    do_read(3'd5, lo);
    do_read(3'd6, hi);
    v = {hi, lo};
  endtask

  // Drives one pulse; the end event happens at the posedge after return.
  task automatic run_pulse(input int hi_len, input int tot, input bit lo,
                           input bit mid, input bit rehi, input bit mid_rd,
                           input bit end_rd, input logic [2:0] end_addr);
    for (int k = 0; k < tot; k++) begin
      @(negedge clk);
      pulse_on = 1'b1;
      a_hi  = (k < hi_len) || (rehi && k >= hi_len + 2);
      a_mid = a_hi ? 1'b1 : mid;
      a_lo  = a_hi ? 1'b1 : lo;
      if (mid_rd && k == 2) begin
        h_addr = 3'd5;
        h_rd   = 1'b1;
      end
      if (mid_rd && k == 3) begin
        h_rd    = 1'b0;
        mid_val = h_rdata;
      end
    end
    @(negedge clk);
    pulse_on = 1'b0;
    a_hi = 1'b0;
    a_mid = 1'b0;
    a_lo = 1'b0;
    if (end_rd) begin
      h_addr = end_addr;
      h_rd   = 1'b1;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] d, d2;
    int dv;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R9 rdata after reset", h_rdata, 0);
    for (int a = 0; a < 8; a++) begin
      do_read(3'(a), d);
      check(a == 7 ? "R5 unused address" : "R9 reset register", d, 0);
    end

    // Table of pulse shapes: R1 delay and R4 class
    for (int i = 0; i < NV; i++) begin
      run_pulse(VECS[i].hi_len, VECS[i].tot, VECS[i].lo, VECS[i].mid,
                1'b0, 1'b0, 1'b0, 3'd0);
      read_dly(dv);
      check("R1 delay count", dv, VECS[i].dly);
      do_read(VECS[i].cls, d);
      check("R4 class counter", d, 1);
    end

    // R3: on-time 300 ticks through both bytes
    do_write(3'd0, 8'h2C);
    do_write(3'd1, 8'h01);
    run_pulse(260, 270, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0);
    do_read(A_ERO, d);
    check("R3 on-time 300 gives erosion", d, 1);
    do_read(3'd5, d);
    check("R8 delay low byte", d, 8'h04);
    // R8: snapshot survives a later pulse
    run_pulse(5, 10, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0);
    do_read(3'd6, d);
    check("R8 high byte from snapshot", d, 8'h01);
    read_dly(dv);
    check("R8 fresh pair", dv, 5);
    do_read(A_ERO, d);
    check("R3 second erosion count", d, 1);
    do_write(3'd0, 8'd20);
    do_write(3'd1, 8'd0);

    // R1: a second rise of the high comparator is ignored
    run_pulse(4, 12, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0);
    read_dly(dv);
    check("R1 later rise ignored", dv, 4);
    do_read(A_ERO, d);

    // R2: read during a pulse returns the previous delay
    run_pulse(9, 12, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0);
    check("R2 mid-pulse read", mid_val, 4);
    read_dly(dv);
    check("R2 latched after end", dv, 9);
    do_read(A_ERO, d);

    // R5: read data holds without a read
    repeat (5) @(negedge clk);
    check("R5 rdata held", h_rdata, 1);

    // R6: saturation of a class counter
    for (int n = 0; n < 260; n++) run_pulse(0, 2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0);
    do_read(A_ARC, d);
    check("R6 saturated at 0xFF", d, 8'hFF);
    do_read(A_ARC, d);
    check("R7 cleared by read", d, 0);

    // R7: read coinciding with an increment
    run_pulse(0, 2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0);
    run_pulse(0, 2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0);
    run_pulse(0, 2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, A_ARC);
    @(negedge clk);
    h_rd = 1'b0;
    d2 = h_rdata;
    check("R7 old value on same-cycle read", d2, 2);
    do_read(A_ARC, d);
    check("R7 increment kept", d, 1);

    // R1: delay saturates at 0xFFFF, no breakdown is open (R4)
    run_pulse(65540, 65540, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0);
    read_dly(dv);
    check("R1 delay saturates", dv, 16'hFFFF);
    do_read(A_OPN, d);
    check("R4 no breakdown is open", d, 1);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule